// File: doc/BRIEF.md
# Software-Loaded Address Translation Buffer

This block turns a 64-bit virtual address into a 32-bit physical address within the same cycle. It holds a fully associative set of translation rows, 32 by default, that software fills. Each row pairs one virtual tag with two frame words, one for the even page and one for the odd page of a page pair, plus a page-size mask. Two address windows skip the rows entirely and pass the low 32 address bits through unchanged. A lookup that finds no usable row raises a miss flag and presents the refill exception code, which the surrounding core uses to take the trap.

Software manages the rows through a single operation port that accepts one operation per cycle. It can write the row named by an index, write a row chosen by a free-running rotating slot that never reaches the lowest rows, probe the rows for a tag, or read one row back. Probe and read results are registered and appear on the outputs one clock after the operation.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every row is empty: any address outside the two bypass windows misses, a probe of any tag reports no match, `index_out` reads 0x80000000 and the read-back outputs read zero.
- R2: When `va[63:62]` is 2'b10 the lookup hits and `pa` equals `va[31:0]`, whatever the rows hold.
- R3: Otherwise, when `va[31:0]` lies in 0x80000000 to 0xBFFFFFFF inclusive, the lookup hits and `pa` equals `va[31:0]`; 0x7FFFFFFF and 0xC0000000 go through the rows.
- R4: A written row matches when its tag word and `va` agree in bits 31:13, ignoring every bit position 13 to 31 that is set in the row's mask word.
- R5: The page shift is 12 when mask bits 31:13 are all zero, and otherwise the position of the highest set mask bit in 31:13; `va` at the page-shift position picks the odd frame word when 1 and the even one when 0, and the `va` bits below that position form the page offset.
- R6: If bit 1 of the picked frame word is 0, the lookup misses even though a row matched.
- R7: On a hit through the rows, `pa` equals (frame word bits 25:6 shifted left by 12) ORed with the page offset.
- R8: `hit` and `miss` are never both high; on a miss `exc_code` is 2, otherwise 0.
- R9: Operation code 1 writes {`ehi_in`, `pmask_in`, `elo0_in`, `elo1_in`} into the row at `index_in[4:0]`; code 4 presents that row's four words on the read-back outputs one clock later.
- R10: `rand_slot` stays within 8 to 31, steps by one every clock and wraps from 31 to 8; operation code 2 writes the four input words into the row `rand_slot` names in that cycle, leaving rows 0 to 7 untouched.
- R11: Operation code 3 compares `ehi_in[31:13]` exactly against the tag bits 31:13 of every written row and, one clock later, shows the lowest matching row number on `index_out`, or 0x80000000 when none matches.
- R12: When several rows match a lookup, the lowest-numbered one supplies the translation; code 0 is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| va | input | 64 | Virtual address to translate |
| pa | output | 32 | Physical address |
| hit | output | 1 | Translation is usable |
| miss | output | 1 | No usable row; refill needed |
| exc_code | output | 5 | Exception code, 2 on a miss |
| op | input | 3 | Operation: 0 idle, 1 indexed write, 2 rotating write, 3 probe, 4 indexed read |
| index_in | input | 32 | Row number for indexed write and read (bits 4:0) |
| ehi_in | input | 32 | Tag word to write or probe |
| pmask_in | input | 32 | Page-size mask word to write |
| elo0_in | input | 32 | Even-page frame word to write |
| elo1_in | input | 32 | Odd-page frame word to write |
| index_out | output | 32 | Probe result |
| rd_ehi | output | 32 | Read-back tag word |
| rd_pmask | output | 32 | Read-back mask word |
| rd_elo0 | output | 32 | Read-back even frame word |
| rd_elo1 | output | 32 | Read-back odd frame word |
| rand_slot | output | 5 | Row the next rotating write will use |

## Verification
The assertions watch on every cycle the properties that need no knowledge of the row contents: the two bypass windows passing the address through, hit and miss exclusion with the matching exception code, the rotating slot staying above the protected rows and stepping by one, and the probe result being either a row number or the no-match code. What a lookup returns through the rows depends on what software wrote, so tag masking, even/odd selection, page-size shifts, the valid bit, lowest-row priority and the read-back contents are shown only by the bench, which sweeps every row, both pages and several offsets against its own arithmetic model of the written rows.

// File: rtl/tlb_xl_pkg.sv
`timescale 1ns/1ps
package tlb_xl_pkg;

   localparam int WORD_W     = 32;
   localparam int TAG_LSB    = 13;
   localparam int PAGE_SHIFT = 12;
   localparam int PFN_LSB    = 6;
   localparam int PFN_MSB    = 25;
   localparam int VALID_BIT  = 1;

   localparam logic [WORD_W-1:0] PROBE_NONE = 32'h8000_0000;
   localparam logic [4:0]        EXC_REFILL = 5'd2;
   localparam logic [4:0]        EXC_NONE   = 5'd0;

   typedef enum logic [2:0] {
      MOP_IDLE   = 3'd0,
      MOP_WR_IDX = 3'd1,
      MOP_WR_RND = 3'd2,
      MOP_PROBE  = 3'd3,
      MOP_RD_IDX = 3'd4
   } mop_e;

   typedef struct packed {
      logic [WORD_W-1:0] vtag;
      logic [WORD_W-1:0] size_mask;
      logic [WORD_W-1:0] frame_even;
      logic [WORD_W-1:0] frame_odd;
   } tlb_row_t;

endpackage

// File: rtl/tlb_first_hit.sv
`timescale 1ns/1ps
module tlb_first_hit #(
   parameter  int W  = 32,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end

endmodule

// File: rtl/tlb_rand_slot.sv
`timescale 1ns/1ps
module tlb_rand_slot #(
   parameter  int ROWS  = 32,
   parameter  int FLOOR = 8,
   localparam int IW    = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int SPAN  = ROWS - FLOOR,
   localparam int CW    = (SPAN > 1) ? $clog2(SPAN) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [IW-1:0] slot
);

   logic [CW-1:0] step_q;

   generate
      if (SPAN > 1) begin : g_rotate
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               step_q <= '0;
            else if (step_q == CW'(SPAN - 1))
               step_q <= '0;
            else
               step_q <= step_q + CW'(1);
         end
      end else begin : g_fixed
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               step_q <= '0;
            else
               step_q <= '0;
         end
      end
   endgenerate

   assign slot = IW'(FLOOR) + IW'(step_q);

endmodule

// File: rtl/tlb_page_fmt.sv
`timescale 1ns/1ps
module tlb_page_fmt
   import tlb_xl_pkg::*;
(
   input  logic [WORD_W-1:0] va32,
   input  tlb_row_t          row,
   output logic [WORD_W-1:0] pa,
   output logic              frame_ok
);

   int unsigned       shift;
   logic [WORD_W-1:0] pick;
   logic [WORD_W-1:0] off_mask;

   always_comb begin
      shift = PAGE_SHIFT;
      for (int b = TAG_LSB; b < WORD_W; b++) begin
         if (row.size_mask[b]) shift = b;
      end
      pick     = va32[shift] ? row.frame_odd : row.frame_even;
      off_mask = (WORD_W'(1) << shift) - WORD_W'(1);
      pa       = {pick[PFN_MSB:PFN_LSB], {PAGE_SHIFT{1'b0}}} | (va32 & off_mask);
      frame_ok = pick[VALID_BIT];
   end

endmodule

// File: rtl/tlb_row_store.sv
`timescale 1ns/1ps
module tlb_row_store
   import tlb_xl_pkg::*;
#(
   parameter  int ROWS = 32,
   localparam int IW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IW-1:0]     wr_slot,
   input  tlb_row_t          wr_row,
   input  logic [WORD_W-1:0] look_va32,
   input  logic [WORD_W-1:0] probe_tag,
   output logic [ROWS-1:0]   look_hits,
   output logic [ROWS-1:0]   probe_hits,
   input  logic [IW-1:0]     sel_a,
   output tlb_row_t          row_a,
   input  logic [IW-1:0]     sel_b,
   output tlb_row_t          row_b
);

   tlb_row_t rows [ROWS];

   generate
      for (genvar g = 0; g < ROWS; g++) begin : g_row
         tlb_row_t r_q;
         logic     live_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r_q    <= '0;
               live_q <= 1'b0;
            end else if (wr_en && wr_slot == IW'(g)) begin
               r_q    <= wr_row;
               live_q <= 1'b1;
            end
         end

         assign rows[g] = r_q;

         assign look_hits[g] = live_q &&
            (((r_q.vtag[WORD_W-1:TAG_LSB] ^ look_va32[WORD_W-1:TAG_LSB]) &
              ~r_q.size_mask[WORD_W-1:TAG_LSB]) == '0);

         assign probe_hits[g] = live_q &&
            (r_q.vtag[WORD_W-1:TAG_LSB] == probe_tag[WORD_W-1:TAG_LSB]);
      end
   endgenerate

   assign row_a = rows[sel_a];
   assign row_b = rows[sel_b];

endmodule

// File: rtl/tlb_xlate.sv
`timescale 1ns/1ps
module tlb_xlate
   import tlb_xl_pkg::*;
#(
   parameter  int ROWS       = 32,
   parameter  int RAND_FLOOR = 8,
   parameter  int VA_W       = 64,
   localparam int IW         = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VA_W-1:0]   va,
   output logic [WORD_W-1:0] pa,
   output logic              hit,
   output logic              miss,
   output logic [4:0]        exc_code,
   input  logic [2:0]        op,
   input  logic [WORD_W-1:0] index_in,
   input  logic [WORD_W-1:0] ehi_in,
   input  logic [WORD_W-1:0] pmask_in,
   input  logic [WORD_W-1:0] elo0_in,
   input  logic [WORD_W-1:0] elo1_in,
   output logic [WORD_W-1:0] index_out,
   output logic [WORD_W-1:0] rd_ehi,
   output logic [WORD_W-1:0] rd_pmask,
   output logic [WORD_W-1:0] rd_elo0,
   output logic [WORD_W-1:0] rd_elo1,
   output logic [IW-1:0]     rand_slot
);

   generate
      if (ROWS < 2 || ROWS > 64) begin : g_bad_rows
         $error("tlb_xlate: ROWS must lie in 2..64");
      end
      if (RAND_FLOOR < 0 || RAND_FLOOR >= ROWS) begin : g_bad_floor
         $error("tlb_xlate: RAND_FLOOR must lie below ROWS");
      end
      if (VA_W < WORD_W + 2) begin : g_bad_va
         $error("tlb_xlate: VA_W must leave room for the window bits");
      end
   endgenerate

   mop_e mop;
   assign mop = mop_e'(op);

   // ---------------- address windows ----------------
   logic [WORD_W-1:0] va32;
   logic              win_direct;
   logic              kseg_direct;
   logic              bypass;

   assign va32        = va[WORD_W-1:0];
   assign win_direct  = (va[VA_W-1:VA_W-2] == 2'b10);
   assign kseg_direct = (va32[WORD_W-1:WORD_W-2] == 2'b10);
   assign bypass      = win_direct || kseg_direct;

   // ---------------- row storage ----------------
   logic [ROWS-1:0] look_hits;
   logic [ROWS-1:0] probe_hits;
   logic            wr_en;
   logic [IW-1:0]   wr_slot;
   logic [IW-1:0]   look_idx;
   logic [IW-1:0]   probe_idx;
   logic            look_found;
   logic            probe_found;
   tlb_row_t        wr_row;
   tlb_row_t        look_row;
   tlb_row_t        rd_row;

   assign wr_en   = (mop == MOP_WR_IDX) || (mop == MOP_WR_RND);
   assign wr_slot = (mop == MOP_WR_RND) ? rand_slot : index_in[IW-1:0];
   assign wr_row  = '{vtag: ehi_in, size_mask: pmask_in,
                      frame_even: elo0_in, frame_odd: elo1_in};

   tlb_row_store #(.ROWS(ROWS)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_slot    (wr_slot),
      .wr_row     (wr_row),
      .look_va32  (va32),
      .probe_tag  (ehi_in),
      .look_hits  (look_hits),
      .probe_hits (probe_hits),
      .sel_a      (look_idx),
      .row_a      (look_row),
      .sel_b      (index_in[IW-1:0]),
      .row_b      (rd_row)
   );

   tlb_first_hit #(.W(ROWS)) u_look_pick (
      .req   (look_hits),
      .found (look_found),
      .idx   (look_idx)
   );

   tlb_first_hit #(.W(ROWS)) u_probe_pick (
      .req   (probe_hits),
      .found (probe_found),
      .idx   (probe_idx)
   );

   tlb_rand_slot #(.ROWS(ROWS), .FLOOR(RAND_FLOOR)) u_rand (
      .clk   (clk),
      .rst_n (rst_n),
      .slot  (rand_slot)
   );

   // ---------------- page format and result ----------------
   logic [WORD_W-1:0] mapped_pa;
   logic              frame_ok;
   logic              mapped_ok;

   tlb_page_fmt u_fmt (
      .va32     (va32),
      .row      (look_row),
      .pa       (mapped_pa),
      .frame_ok (frame_ok)
   );

   assign mapped_ok = look_found && frame_ok;

   always_comb begin
      if (bypass) begin
         pa       = va32;
         hit      = 1'b1;
         miss     = 1'b0;
         exc_code = EXC_NONE;
      end else begin
         pa       = mapped_ok ? mapped_pa : '0;
         hit      = mapped_ok;
         miss     = !mapped_ok;
         exc_code = mapped_ok ? EXC_NONE : EXC_REFILL;
      end
   end

   // ---------------- maintenance results ----------------
   logic [WORD_W-1:0] index_q;
   tlb_row_t          rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         index_q <= PROBE_NONE;
         rd_q    <= '0;
      end else begin
         if (mop == MOP_PROBE)
            index_q <= probe_found ? WORD_W'(probe_idx) : PROBE_NONE;
         if (mop == MOP_RD_IDX)
            rd_q <= rd_row;
      end
   end

   assign index_out = index_q;
   assign rd_ehi    = rd_q.vtag;
   assign rd_pmask  = rd_q.size_mask;
   assign rd_elo0   = rd_q.frame_even;
   assign rd_elo1   = rd_q.frame_odd;

endmodule

// File: rtl/tlb_xlate_chk.sv
`timescale 1ns/1ps
module tlb_xlate_chk #(
   parameter  int ROWS       = 32,
   parameter  int RAND_FLOOR = 8,
   parameter  int VA_W       = 64,
   localparam int IW         = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [VA_W-1:0] va,
   input logic [31:0]     pa,
   input logic            hit,
   input logic            miss,
   input logic [4:0]      exc_code,
   input logic [31:0]     index_out,
   input logic [IW-1:0]   rand_slot
);

   AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit && miss)); // R8

   AST_REFILL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      miss |-> exc_code == 5'd2); // R8

   AST_QUIET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      !miss |-> exc_code == 5'd0); // R8

   AST_WIDE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (va[VA_W-1:VA_W-2] == 2'b10) |-> (hit && pa == va[31:0])); // R2

   AST_KERNEL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (va[VA_W-1:VA_W-2] != 2'b10 && va[31:30] == 2'b10) |-> (hit && pa == va[31:0])); // R3

   AST_RAND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rand_slot) >= RAND_FLOOR) && (int'(rand_slot) < ROWS)); // R10

   AST_RAND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (int'(rand_slot) == ((int'($past(rand_slot)) == ROWS - 1) ?
                                     RAND_FLOOR : int'($past(rand_slot)) + 1))); // R10

   AST_PROBE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (index_out == 32'h8000_0000) || (index_out < 32'(ROWS))); // R11

endmodule

bind tlb_xlate tlb_xlate_chk #(
   .ROWS       (ROWS),
   .RAND_FLOOR (RAND_FLOOR),
   .VA_W       (VA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .va        (va),
   .pa        (pa),
   .hit       (hit),
   .miss      (miss),
   .exc_code  (exc_code),
   .index_out (index_out),
   .rand_slot (rand_slot)
);

// File: tb/tb_tlb_xlate.sv
`timescale 1ns/1ps
module tb_tlb_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] va = '0;
   logic [31:0] pa;
   logic        hit, miss;
   logic [4:0]  exc_code;
   logic [2:0]  op = 3'd0;
   logic [31:0] index_in = '0, ehi_in = '0, pmask_in = '0, elo0_in = '0, elo1_in = '0;
   logic [31:0] index_out, rd_ehi, rd_pmask, rd_elo0, rd_elo1;
   logic [4:0]  rand_slot;

   always #10 clk = ~clk;

   tlb_xlate dut (
      .clk(clk), .rst_n(rst_n), .va(va), .pa(pa), .hit(hit), .miss(miss),
      .exc_code(exc_code), .op(op), .index_in(index_in), .ehi_in(ehi_in),
      .pmask_in(pmask_in), .elo0_in(elo0_in), .elo1_in(elo1_in),
      .index_out(index_out), .rd_ehi(rd_ehi), .rd_pmask(rd_pmask),
      .rd_elo0(rd_elo0), .rd_elo1(rd_elo1), .rand_slot(rand_slot)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [31:0] m_hi [32];
   logic [31:0] m_mk [32];
   logic [31:0] m_l0 [32];
   logic [31:0] m_l1 [32];
   bit          m_v  [32];
   logic [4:0]  last_rnd;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp_v);
      end
   endtask

   // expected translation computed from the written rows
   task automatic model(input logic [63:0] v, output logic [31:0] epa, output bit eh);
      int sl, sh;
      logic [31:0] lo;
      epa = '0; eh = 1'b0;
      if (v[63:62] == 2'b10 || v[31:30] == 2'b10) begin
         epa = v[31:0]; eh = 1'b1; return;
      end
      sl = -1;
      for (int i = 31; i >= 0; i--)
         if (m_v[i] && (((m_hi[i][31:13] ^ v[31:13]) & ~m_mk[i][31:13]) == 19'd0)) sl = i;
      if (sl < 0) return;
      sh = 12;
      for (int b = 13; b < 32; b++) if (m_mk[sl][b]) sh = b;
      lo = v[sh] ? m_l1[sl] : m_l0[sl];
      if (!lo[1]) return;
      eh  = 1'b1;
      epa = ({12'd0, lo[25:6]} * 32'd4096) | (v[31:0] % (32'd1 << sh));
   endtask

   task automatic mop(input logic [2:0] o, input logic [31:0] idx, hi, mk, l0, l1);
      @(negedge clk);
      op = o; index_in = idx; ehi_in = hi; pmask_in = mk; elo0_in = l0; elo1_in = l1;
      last_rnd = rand_slot;
      if (o == 3'd1 || o == 3'd2) begin
         int s;
         s = (o == 3'd1) ? int'(idx[4:0]) : int'(rand_slot);
         m_hi[s] = hi; m_mk[s] = mk; m_l0[s] = l0; m_l1[s] = l1; m_v[s] = 1'b1;
      end
      @(negedge clk);
      op = 3'd0;
   endtask

   task automatic look(input logic [63:0] v, input string req);
      logic [31:0] epa;
      bit eh;
      @(negedge clk);
      va = v;
      #2;
      model(v, epa, eh);
      chk(hit == eh, req, 64'(hit), 64'(eh));
      chk(miss == !eh, "R8", 64'(miss), 64'(!eh));
      chk(exc_code == (eh ? 5'd0 : 5'd2), "R8", 64'(exc_code), eh ? 64'd0 : 64'd2);
      if (eh) chk(pa == epa, req, 64'(pa), 64'(epa));
   endtask

   task automatic rd_row(input int s, input string req);
      mop(3'd4, 32'(s), 0, 0, 0, 0);
      chk(rd_ehi   == (m_v[s] ? m_hi[s] : 32'd0), req, 64'(rd_ehi),   64'(m_hi[s]));
      chk(rd_pmask == (m_v[s] ? m_mk[s] : 32'd0), req, 64'(rd_pmask), 64'(m_mk[s]));
      chk(rd_elo0  == (m_v[s] ? m_l0[s] : 32'd0), req, 64'(rd_elo0),  64'(m_l0[s]));
      chk(rd_elo1  == (m_v[s] ? m_l1[s] : 32'd0), req, 64'(rd_elo1),  64'(m_l1[s]));
   endtask

   task automatic probe(input logic [31:0] tag, input logic [31:0] expv, input string req);
      mop(3'd3, 0, tag, 0, 0, 0);
      chk(index_out == expv, req, 64'(index_out), 64'(expv));
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [4:0] prev;
      for (int i = 0; i < 32; i++) begin
         m_hi[i] = '0; m_mk[i] = '0; m_l0[i] = '0; m_l1[i] = '0; m_v[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: empty after reset
      @(negedge clk);
      chk(index_out == 32'h8000_0000, "R1", 64'(index_out), 64'h8000_0000);
      chk(rd_ehi == 32'd0 && rd_elo0 == 32'd0, "R1", 64'(rd_ehi), 64'd0);
      look(64'h0000_0000_0000_1000, "R1");
      look(64'h0000_0000_0123_4000, "R1");
      probe(32'h0000_0000, 32'h8000_0000, "R1");

      // R9: fill every row by index, slot 5 odd page invalid
      for (int i = 0; i < 32; i++)
         mop(3'd1, 32'(i), 32'((i + 1) << 13), 32'd0,
             32'(((32'h100 + i) << 6) | 2), 32'(((32'h200 + i) << 6) | ((i == 5) ? 0 : 2)));

      // R4 R5 R6 R7: sweep rows, pages and offsets
      for (int i = 0; i <= 32; i++)
         for (int h = 0; h < 2; h++) begin
            look(64'(((i + 1) << 13) | (h << 12) | 32'h000), "R7");
            look(64'(((i + 1) << 13) | (h << 12) | 32'hABC), "R5");
            look(64'(((i + 1) << 13) | (h << 12) | 32'hFFF), "R6");
         end

      // R9: read every row back
      for (int i = 0; i < 32; i++) rd_row(i, "R9");

      // R11: probe each tag, low bits ignored
      for (int i = 0; i < 32; i++) probe(32'(((i + 1) << 13) | 32'h1FFF), 32'(i), "R11");
      probe(32'h00FF_E000, 32'h8000_0000, "R11");

      // R2 R3: bypass windows and their edges
      look(64'h8000_0000_1234_5678, "R2");
      look(64'hBFFF_FFFF_0000_4000, "R2");
      look(64'hC000_0000_0000_4010, "R2");
      look(64'h0000_0000_8000_0000, "R3");
      look(64'h0000_0000_BFFF_FFFF, "R3");
      look(64'h0000_0000_7FFF_FFFF, "R3");
      look(64'h0000_0000_C000_0000, "R3");

      // R4 R5: larger pages via mask
      mop(3'd1, 3, 32'h0100_6000, 32'h0000_6000, (32'h345 << 6) | 2, (32'h567 << 6) | 2);
      look(64'h0100_2ABC, "R5");
      look(64'h0100_6ABC, "R5");
      look(64'h0100_0000, "R4");
      look(64'h0100_8000, "R4");
      mop(3'd1, 4, 32'h0200_0000, 32'h0000_2000, (32'h0AA << 6) | 2, (32'h0BB << 6) | 2);
      look(64'h0200_3FFF, "R5");
      look(64'h0200_1234, "R5");

      // R12: two rows with the same tag
      mop(3'd1, 20, 32'h0300_0000, 0, (32'h777 << 6) | 2, (32'h778 << 6) | 2);
      mop(3'd1, 10, 32'h0300_0000, 0, (32'h111 << 6) | 2, (32'h112 << 6) | 2);
      look(64'h0300_0123, "R12");
      look(64'h0300_1123, "R12");
      probe(32'h0300_0000, 32'd10, "R12");
      mop(3'd0, 0, 32'h0500_0000, 0, 0, 0);
      look(64'h0300_0123, "R12");

      // R10: rotating slot steps and wraps
      @(negedge clk);
      prev = rand_slot;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         chk(rand_slot == ((prev == 5'd31) ? 5'd8 : prev + 5'd1), "R10", 64'(rand_slot), 64'(prev));
         prev = rand_slot;
      end
      for (int k = 0; k < 30; k++) begin
         mop(3'd2, 0, 32'(32'h0400_0000 + (k << 13)), 0,
             32'(((32'h900 + k) << 6) | 2), 32'(((32'hA00 + k) << 6) | 2));
         chk(last_rnd >= 5'd8, "R10", 64'(last_rnd), 64'd8);
         rd_row(int'(last_rnd), "R10");
         look(64'(32'h0400_0000 + (k << 13) + 32'h55), "R10");
      end
      for (int i = 0; i < 8; i++) rd_row(i, "R10");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule